// File: doc/BRIEF.md
# Power-Managed System Clock Controller

This block sits between a fast crystal oscillator and the rest of a microcontroller core and decides, on every oscillator cycle, whether that cycle counts as a system clock. It produces a one-cycle-wide system clock enable, not a derived clock. Software picks one of four fast divide ratios or one of two low-power modes. The low-power modes are a long fixed divide, or running from ticks of a slow 32 kHz oscillator. Software can also halt the system clock altogether. The slow oscillator and the internal ring oscillator reach the block as single-cycle tick pulses, already aligned to the fast clock.

When hardware switchback is on, a pending interrupt from an external pin, a serial port or the SPI unit drops the block out of a low-power mode. The block clears the power-management bit itself, so software can see that the mode has changed. An external pin interrupt or a time-of-day alarm wakes the block from the halted state. It then either waits for the crystal to report that warmup is complete, or runs at once from ring-oscillator ticks and moves over to the crystal once warmup is done. A synchronous external reset returns everything to its defaults from any state.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: After reset, `pm_en` is 0, `stopped` is 0, `clk_src` is 0 (crystal), and `sys_en` is high on every cycle (divide-by-1).
- R2: With `pm_en` at 0, `div_sel` values 00, 01, 10 and 11 give a distance of 1, 2, 4 and 8 fast cycles between `sys_en` pulses, with `clk_src` at 0.
- R3: With `pm_en` at 1, `div_sel` 00 gives a distance of 256 fast cycles between pulses. The values 01 and 10 still give 2 and 4.
- R4: With `pm_en` at 1 and `div_sel` at 11, `sys_en` follows `slow_tick` and `clk_src` reads 2.
- R5: A new ratio from the crystal takes effect only after the current period ends. The pulse that closes the old period comes at the old distance, and the new distance applies from there on.
- R6: When `swb_en` is 1 and `pm_en` is 1, any pending interrupt on `irq_ext`, `irq_uart` or `irq_spi` clears `pm_en` on the next edge. The clock then returns to the fast ratio that `div_sel` picks with power management off. With `swb_en` at 0, interrupts leave `pm_en` unchanged.
- R7: One edge after `stop_req`, `stopped` reads 1 and `clk_src` reads 3 (none). No `sys_en` pulse appears while stopped, whatever ticks arrive.
- R8: The halted state is left only on a pending `irq_ext` bit, on `alarm`, or on `ext_rst`. Serial-port and SPI interrupts do not end it.
- R9: With `ring_start` at 0, waking leaves `stopped` at 0 and `clk_src` at 3, and gives no pulses until `warm_done` is high. The edge after that, the block runs from the crystal with a fresh period.
- R10: With `ring_start` at 1, waking makes `sys_en` follow `ring_tick` with `clk_src` at 1. The edge after the first ring pulse seen while `warm_done` is high moves the block to the crystal (`clk_src` 0), and a full new crystal period starts there.
- R11: `ext_rst` returns the block to the R1 state from any state, including the halted state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast crystal oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_rst | input | 1 | Synchronous external reset request |
| div_sel | input | 2 | Divide / mode select field |
| pm_wr | input | 1 | Write strobe for the power-management bit |
| pm_wdata | input | 1 | Value written to the power-management bit |
| swb_en | input | 1 | Hardware switchback enable |
| stop_req | input | 1 | Request to halt the system clock |
| ring_start | input | 1 | 1: run from ring ticks during crystal warmup after wake |
| irq_ext | input | N_EXT | Pending, enabled external pin interrupts |
| irq_uart | input | N_UART | Pending, enabled serial-port interrupts |
| irq_spi | input | 1 | Pending, enabled SPI interrupt |
| alarm | input | 1 | Time-of-day alarm event |
| warm_done | input | 1 | Crystal warmup complete |
| ring_tick | input | 1 | Ring oscillator tick, one fast cycle wide |
| slow_tick | input | 1 | 32 kHz oscillator tick, one fast cycle wide |
| sys_en | output | 1 | System clock enable for this fast cycle |
| clk_src | output | 2 | Active source: 0 crystal, 1 ring, 2 slow, 3 none |
| stopped | output | 1 | Block is in the halted state |
| pm_en | output | 1 | Current power-management bit |

## Verification
Changes to `pm_en`, `stopped` and `clk_src` are registered, so each appears one edge after the cycle that carries the write, interrupt, stop request or wake event. The bench drives inputs on the falling edge and checks those outputs at the next falling edge. `sys_en` is combinational from the divider state and the tick inputs. A new ratio shows up only after the enable that closes the old period. For that reason, every ratio measurement lets two enables pass and then times the third gap. The one directed case that changes the ratio mid-period counts cycles to the closing pulse (6) and then to the next one (1). The move from ring to crystal is checked at the sample right after the last ring pulse. The first crystal pulse is expected one further sample after that.

// File: rtl/pwr_clk_pkg.sv
package pwr_clk_pkg;

  typedef enum logic [2:0] {
    MD_DIV1   = 3'd0,
    MD_DIV2   = 3'd1,
    MD_DIV4   = 3'd2,
    MD_DIV8   = 3'd3,
    MD_DIV_LP = 3'd4,
    MD_SLOW   = 3'd5
  } clk_mode_t;

  typedef enum logic [1:0] {
    SRC_XTAL = 2'd0,
    SRC_RING = 2'd1,
    SRC_SLOW = 2'd2,
    SRC_NONE = 2'd3
  } clk_src_t;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_STOP = 2'd1,
    ST_WARM = 2'd2,
    ST_RING = 2'd3
  } pwr_state_t;

  // Operating mode from the power-management bit and the divide field.
  function automatic clk_mode_t pick_mode(input logic pm, input logic [1:0] div);
    clk_mode_t m;
    if (pm) begin
      case (div)
        2'b00:   m = MD_DIV_LP;
        2'b01:   m = MD_DIV2;
        2'b10:   m = MD_DIV4;
        default: m = MD_SLOW;
      endcase
    end else begin
      case (div)
        2'b00:   m = MD_DIV1;
        2'b01:   m = MD_DIV2;
        2'b10:   m = MD_DIV4;
        default: m = MD_DIV8;
      endcase
    end
    return m;
  endfunction

  // Fast cycles per system clock for the crystal-driven modes.
  function automatic int unsigned period_of(input clk_mode_t m, input int unsigned lp);
    int unsigned p;
    case (m)
      MD_DIV2:   p = 2;
      MD_DIV4:   p = 4;
      MD_DIV8:   p = 8;
      MD_DIV_LP: p = lp;
      default:   p = 1;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/pwr_clk_mode_sel.sv
module pwr_clk_mode_sel
  import pwr_clk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_rst,
  input  logic       pm_wr,
  input  logic       pm_wdata,
  input  logic       swb_en,
  input  logic       irq_any,
  input  logic [1:0] div_sel,
  output logic       pm_en,
  output clk_mode_t  want_mode,
  output logic       swb_fire
);

  assign swb_fire  = pm_en & swb_en & irq_any;
  assign want_mode = pick_mode(pm_en, div_sel);

  // Switchback outranks a simultaneous software write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pm_en <= 1'b0;
    else if (ext_rst)  pm_en <= 1'b0;
    else if (swb_fire) pm_en <= 1'b0;
    else if (pm_wr)    pm_en <= pm_wdata;
  end

  // R6
  swb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_en && swb_en && irq_any) |=> !pm_en);

  // R6
  swb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_en && !swb_en && !pm_wr && !ext_rst) |=> pm_en);

endmodule

// File: rtl/pwr_clk_stop_fsm.sv
module pwr_clk_stop_fsm
  import pwr_clk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_rst,
  input  logic       stop_req,
  input  logic       wake,
  input  logic       ring_start,
  input  logic       warm_done,
  input  logic       ring_tick,
  output pwr_state_t state
);

  pwr_state_t nxt;
  logic       ring_handover;

  assign ring_handover = ring_tick & warm_done;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_RUN:  if (stop_req) nxt = ST_STOP;
      ST_STOP: if (wake) nxt = ring_start ? ST_RING : ST_WARM;
      ST_WARM: if (warm_done) nxt = ST_RUN;
      ST_RING: begin
        if (stop_req)           nxt = ST_STOP;
        else if (ring_handover) nxt = ST_RUN;
      end
      default: nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state <= ST_RUN;
    else if (ext_rst) state <= ST_RUN;
    else              state <= nxt;
  end

  // R8
  stop_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_STOP && state != ST_STOP && !$past(ext_rst)) |-> $past(wake));

  // R10
  ring_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_RING && state == ST_RUN && !$past(ext_rst))
      |-> $past(warm_done && ring_tick));

  // R11
  ext_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rst |=> (state == ST_RUN));

endmodule

// File: rtl/pwr_clk_divider.sv
module pwr_clk_divider
  import pwr_clk_pkg::*;
#(
  parameter int unsigned LP_DIV = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_rst,
  input  pwr_state_t state,
  input  clk_mode_t  want_mode,
  input  logic       ring_tick,
  input  logic       slow_tick,
  output logic       sys_en,
  output clk_src_t   src
);

  localparam int CNT_W = $clog2(LP_DIV);

  clk_mode_t        act_mode;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last_cnt;
  logic             xtal_edge;
  logic             take_new;

  assign last_cnt  = CNT_W'(period_of(act_mode, LP_DIV) - 1);
  assign xtal_edge = (act_mode != MD_SLOW) && (cnt == last_cnt);
  // The crystal period ends at its enable; the slow source carries no crystal count.
  assign take_new  = xtal_edge || (act_mode == MD_SLOW);

  always_comb begin
    case (state)
      ST_RUN:  sys_en = (act_mode == MD_SLOW) ? slow_tick : xtal_edge;
      ST_RING: sys_en = ring_tick;
      default: sys_en = 1'b0;
    endcase
  end

  always_comb begin
    case (state)
      ST_RUN:  src = (act_mode == MD_SLOW) ? SRC_SLOW : SRC_XTAL;
      ST_RING: src = SRC_RING;
      default: src = SRC_NONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      act_mode <= MD_DIV1;
    end else if (ext_rst) begin
      cnt      <= '0;
      act_mode <= MD_DIV1;
    end else if (state != ST_RUN) begin
      cnt      <= '0;
      act_mode <= want_mode;
    end else if (take_new) begin
      cnt      <= '0;
      act_mode <= want_mode;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R5
  ratio_at_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_RUN && state == ST_RUN && !$past(ext_rst)
      && $past(act_mode) != MD_SLOW && act_mode != $past(act_mode)) |-> $past(sys_en));

  // R9
  warm_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WARM) |-> (!sys_en && src == SRC_NONE));

endmodule

// File: rtl/pwr_clk_ctrl.sv
module pwr_clk_ctrl
  import pwr_clk_pkg::*;
#(
  parameter int unsigned N_EXT  = 16,
  parameter int unsigned N_UART = 2,
  parameter int unsigned LP_DIV = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_rst,
  input  logic [1:0]        div_sel,
  input  logic              pm_wr,
  input  logic              pm_wdata,
  input  logic              swb_en,
  input  logic              stop_req,
  input  logic              ring_start,
  input  logic [N_EXT-1:0]  irq_ext,
  input  logic [N_UART-1:0] irq_uart,
  input  logic              irq_spi,
  input  logic              alarm,
  input  logic              warm_done,
  input  logic              ring_tick,
  input  logic              slow_tick,
  output logic              sys_en,
  output logic [1:0]        clk_src,
  output logic              stopped,
  output logic              pm_en
);

  logic       irq_any;
  logic       wake;
  logic       swb_fire;
  clk_mode_t  want_mode;
  pwr_state_t state;
  clk_src_t   src;

  assign irq_any = (|irq_ext) | (|irq_uart) | irq_spi;
  assign wake    = (|irq_ext) | alarm;

  pwr_clk_mode_sel u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_rst   (ext_rst),
    .pm_wr     (pm_wr),
    .pm_wdata  (pm_wdata),
    .swb_en    (swb_en),
    .irq_any   (irq_any),
    .div_sel   (div_sel),
    .pm_en     (pm_en),
    .want_mode (want_mode),
    .swb_fire  (swb_fire)
  );

  pwr_clk_stop_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_rst    (ext_rst),
    .stop_req   (stop_req),
    .wake       (wake),
    .ring_start (ring_start),
    .warm_done  (warm_done),
    .ring_tick  (ring_tick),
    .state      (state)
  );

  pwr_clk_divider #(.LP_DIV(LP_DIV)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_rst   (ext_rst),
    .state     (state),
    .want_mode (want_mode),
    .ring_tick (ring_tick),
    .slow_tick (slow_tick),
    .sys_en    (sys_en),
    .src       (src)
  );

  assign clk_src = src;
  assign stopped = (state == ST_STOP);

  // R7
  stop_no_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |-> (!sys_en && clk_src == 2'd3));

  // R6
  swb_pm_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swb_fire |=> !pm_en);

endmodule

// File: tb/pwr_clk_ctrl_tb_top.sv
module pwr_clk_ctrl_tb_top;

  localparam int RING_P = 6;
  localparam int SLOW_P = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_rst = 1'b0;
  logic [1:0]  div_sel = 2'b00;
  logic        pm_wr = 1'b0;
  logic        pm_wdata = 1'b0;
  logic        swb_en = 1'b0;
  logic        stop_req = 1'b0;
  logic        ring_start = 1'b0;
  logic [15:0] irq_ext = '0;
  logic [1:0]  irq_uart = '0;
  logic        irq_spi = 1'b0;
  logic        alarm = 1'b0;
  logic        warm_done = 1'b0;
  logic        ring_tick = 1'b0;
  logic        slow_tick = 1'b0;
  logic        sys_en;
  logic [1:0]  clk_src;
  logic        stopped;
  logic        pm_en;

  int checks = 0;
  int fails  = 0;
  int ring_c = 0;
  int slow_c = 0;

  // {pm, div[1:0], expected gap[8:0], expected source[1:0]}
  localparam logic [13:0] VEC [8] = '{
    {1'b0, 2'b00, 9'd1,   2'd0},
    {1'b0, 2'b01, 9'd2,   2'd0},
    {1'b0, 2'b10, 9'd4,   2'd0},
    {1'b0, 2'b11, 9'd8,   2'd0},
    {1'b1, 2'b00, 9'd256, 2'd0},
    {1'b1, 2'b11, 9'd40,  2'd2},
    {1'b1, 2'b01, 9'd2,   2'd0},
    {1'b1, 2'b10, 9'd4,   2'd0}
  };

  pwr_clk_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ext_rst(ext_rst), .div_sel(div_sel),
    .pm_wr(pm_wr), .pm_wdata(pm_wdata), .swb_en(swb_en), .stop_req(stop_req),
    .ring_start(ring_start), .irq_ext(irq_ext), .irq_uart(irq_uart),
    .irq_spi(irq_spi), .alarm(alarm), .warm_done(warm_done),
    .ring_tick(ring_tick), .slow_tick(slow_tick), .sys_en(sys_en),
    .clk_src(clk_src), .stopped(stopped), .pm_en(pm_en)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    ring_c    <= (ring_c == RING_P - 1) ? 0 : ring_c + 1;
    ring_tick <= (ring_c == RING_P - 1);
    slow_c    <= (slow_c == SLOW_P - 1) ? 0 : slow_c + 1;
    slow_tick <= (slow_c == SLOW_P - 1);
  end

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic next_en(output int n);
    n = 0;
    do begin
      step();
      n++;
    end while (!sys_en && n < 2000);
  endtask

  task automatic gap(output int g);
    int a;
    int b;
    next_en(a);
    next_en(b);
    next_en(g);
  endtask

  task automatic set_cfg(input logic pm, input logic [1:0] div);
    @(negedge clk);
    pm_wr = 1'b1; pm_wdata = pm; div_sel = div;
    @(negedge clk);
    pm_wr = 1'b0;
    #1;
  endtask

  task automatic do_stop();
    @(negedge clk); stop_req = 1'b1;
    @(negedge clk); stop_req = 1'b0;
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    report();
    $finish;
  end

  initial begin
    int g;
    int n;
    int cnt_en;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk("R1 pm_en", int'(pm_en), 0);
    chk("R1 stopped", int'(stopped), 0);
    chk("R1 clk_src", int'(clk_src), 0);
    cnt_en = 0;
    for (int i = 0; i < 4; i++) begin
      cnt_en += int'(sys_en);
      step();
    end
    chk("R1 enable every cycle", cnt_en, 4);

    // R2 / R3 / R4 ratio table
    for (int i = 0; i < 8; i++) begin
      set_cfg(VEC[i][13], VEC[i][12:11]);
      gap(g);
      if (VEC[i][13] && VEC[i][12:11] == 2'b11) begin
        chk("R4 slow gap", g, int'(VEC[i][10:2]));
        chk("R4 slow source", int'(clk_src), int'(VEC[i][1:0]));
      end else if (VEC[i][13]) begin
        chk("R3 pm gap", g, int'(VEC[i][10:2]));
        chk("R3 source", int'(clk_src), int'(VEC[i][1:0]));
      end else begin
        chk("R2 gap", g, int'(VEC[i][10:2]));
        chk("R2 source", int'(clk_src), int'(VEC[i][1:0]));
      end
    end

    // R5 change mid-period: old divide-by-8 period completes first
    set_cfg(1'b0, 2'b11);
    gap(g);
    set_cfg(1'b0, 2'b00);
    next_en(n);
    chk("R5 old period completes", n, 6);
    next_en(n);
    chk("R5 new ratio after edge", n, 1);

    // R6 switchback
    set_cfg(1'b1, 2'b00);
    gap(g);
    chk("R3 divide-by-256", g, 256);
    @(negedge clk); irq_uart = 2'b01;
    @(negedge clk); irq_uart = 2'b00;
    #1;
    chk("R6 no switchback when disabled", int'(pm_en), 1);
    @(negedge clk); swb_en = 1'b1; irq_spi = 1'b1;
    @(negedge clk); irq_spi = 1'b0;
    #1;
    chk("R6 pm_en cleared by spi", int'(pm_en), 0);
    gap(g);
    chk("R6 fast ratio after switchback", g, 1);
    set_cfg(1'b1, 2'b11);
    gap(g);
    chk("R4 slow gap again", g, SLOW_P);
    @(negedge clk); irq_ext = 16'h0004;
    @(negedge clk); irq_ext = '0;
    #1;
    chk("R6 pm_en cleared by ext irq", int'(pm_en), 0);
    gap(g);
    chk("R6 divide-by-8 after slow exit", g, 8);
    chk("R6 source crystal", int'(clk_src), 0);
    swb_en = 1'b0;

    // R7 / R8 / R9 stop, ignored wakes, alarm wake without ring
    set_cfg(1'b0, 2'b00);
    do_stop();
    chk("R7 stopped", int'(stopped), 1);
    chk("R7 source none", int'(clk_src), 3);
    cnt_en = 0;
    for (int i = 0; i < 300; i++) begin
      step();
      cnt_en += int'(sys_en);
    end
    chk("R7 no enables while stopped", cnt_en, 0);
    @(negedge clk); irq_uart = 2'b10; irq_spi = 1'b1;
    @(negedge clk); irq_uart = 2'b00; irq_spi = 1'b0;
    #1;
    chk("R8 serial/spi do not wake", int'(stopped), 1);
    ring_start = 1'b0;
    @(negedge clk); alarm = 1'b1;
    @(negedge clk); alarm = 1'b0;
    #1;
    chk("R8 alarm wakes", int'(stopped), 0);
    chk("R9 source none while warming", int'(clk_src), 3);
    cnt_en = 0;
    for (int i = 0; i < 20; i++) begin
      step();
      cnt_en += int'(sys_en);
    end
    chk("R9 no enables before warmup", cnt_en, 0);
    @(negedge clk); warm_done = 1'b1;
    step();
    chk("R9 crystal after warmup", int'(clk_src), 0);
    chk("R9 enable resumes", int'(sys_en), 1);

    // R10 ring start during warmup, external pin wake
    set_cfg(1'b0, 2'b01);
    warm_done = 1'b0;
    ring_start = 1'b1;
    do_stop();
    chk("R7 stopped again", int'(stopped), 1);
    @(negedge clk); irq_ext = 16'h0020;
    @(negedge clk); irq_ext = '0;
    #1;
    chk("R8 ext irq wakes", int'(stopped), 0);
    chk("R10 ring source", int'(clk_src), 1);
    gap(g);
    chk("R10 ring gap", g, RING_P);
    @(negedge clk); warm_done = 1'b1;
    next_en(n);
    chk("R10 last ring enable on ring", int'(clk_src), 1);
    step();
    chk("R10 crystal after handover", int'(clk_src), 0);
    next_en(n);
    chk("R10 full period after handover", n, 1);
    gap(g);
    chk("R10 divide-by-2 on crystal", g, 2);
    ring_start = 1'b0;

    // R11 external reset from stop
    set_cfg(1'b1, 2'b10);
    do_stop();
    chk("R7 stopped before ext_rst", int'(stopped), 1);
    @(negedge clk); ext_rst = 1'b1;
    @(negedge clk); ext_rst = 1'b0;
    #1;
    chk("R11 stopped cleared", int'(stopped), 0);
    chk("R11 pm_en cleared", int'(pm_en), 0);
    chk("R11 source crystal", int'(clk_src), 0);
    div_sel = 2'b00;
    gap(g);
    chk("R11 divide-by-1", g, 1);

    report();
    $finish;
  end

endmodule